// File: doc/BRIEF.md
# Bus Window Address Translator

This block converts addresses arriving from a peripheral bus into system memory addresses. It holds four programmable windows. Each window has three 64-bit registers: a window base, a size mask and a target base. A configuration port writes and reads all of these registers, along with one 64-bit control register. The configuration read path is combinational, so `cfg_rdata` always shows the register chosen by `cfg_sel`.

A translation starts when `req_valid` is high while `req_ready` is high. The block then searches the windows. A window in linear mode builds the result directly from its target base. A window in page-table mode first fetches a 64-bit table entry through a memory read port, then builds the result from that entry. When no enabled window matches, the input address is returned unchanged. Only one translation is in flight at a time. Each result is reported by a one-cycle `resp_valid` pulse.

Top module: `bus_window_xlate`

## Requirements
- R1: After reset, every window base, size mask and target base register reads as zero, so all windows are disabled. The control register reads 64'h0000_0021_0010_0000. `req_ready` is 1, and `resp_valid` and `mem_req` are 0.
- R2: Register selection uses `cfg_sel[3:2]` as the register kind and `cfg_sel[1:0]` as the window index. The kinds are 0 = window base, 1 = size mask, 2 = target base and 3 = control; for kind 3 the index bits are ignored. A cycle with `cfg_we` high writes all 64 bits of `cfg_wdata`, and the value reads back unchanged.
- R3: If no enabled window matches, `resp_addr` equals the request address. The result appears one cycle after acceptance, and no memory read is made.
- R4: Bit 0 of a window base enables the window. An enabled window matches when the request address and the window base agree on every bit set in (NOT size mask) AND 64'hFFF0_0000.
- R5: When several enabled windows match, the window with the lowest index is used.
- R6: If bit 1 of the matching base is 0 (linear mode), let F = (size mask AND 64'hFFF0_0000) OR 64'hF_FFFF. Then `resp_addr` = (target base AND NOT F) OR (request AND F), one cycle after acceptance.
- R7: If bit 1 of the matching base is 1 (page-table mode), let G = size mask AND 64'hFFF0_0000. From the cycle after acceptance, `mem_req` is raised with `mem_addr` = (target base AND NOT ((G >> 10) OR 64'h3FF)) OR ((request AND (G OR 64'hF_E000)) >> 10). Both are held until a cycle with `mem_ack` high.
- R8: In page-table mode, `resp_addr` = ((entry AND NOT 1) << 12) OR (request AND 64'h1FFF), where the entry is `mem_data` sampled with `mem_ack`. The result appears in the cycle after that acknowledge.
- R9: `req_ready` is low from the cycle after acceptance through the result cycle, and high again in the cycle after it.
- R10: `resp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Register kind [3:2] and window index [1:0] |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Contents of the selected register |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Ready to accept a request |
| req_addr | input | 64 | Bus address to translate |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_addr | output | 64 | Translated address |
| mem_req | output | 1 | Table entry read request |
| mem_addr | output | 64 | Table entry address |
| mem_ack | input | 1 | Table entry read acknowledge |
| mem_data | input | 64 | Table entry data |

## Verification
Linear and pass-through results are due one cycle after the accepting edge. Each request is driven on a falling edge and the bench counts falling edges from acceptance, so it expects `resp_valid` at count 1 in those cases. In page-table mode the bench checks `mem_addr` at the first falling edge where `mem_req` is high. It then acknowledges after a random delay of 0 to 2 cycles and expects the result exactly one edge after the acknowledge. In the following cycle it checks that `resp_valid` has dropped and `req_ready` is high again.

// File: rtl/bwx_pkg.sv
package bwx_pkg;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_WALK = 2'd1,
        XS_DONE = 2'd2
    } xl_state_e;

    typedef enum logic [1:0] {
        RK_BASE  = 2'd0,
        RK_MASK  = 2'd1,
        RK_TBASE = 2'd2,
        RK_CTRL  = 2'd3
    } reg_kind_e;

    // address bits that take part in the window compare
    localparam logic [63:0] WIN_FIELD  = 64'h0000_0000_FFF0_0000;
    // offset bits always kept in linear mode
    localparam logic [63:0] LIN_LOW    = 64'h0000_0000_000F_FFFF;
    // alignment of the table pointer
    localparam logic [63:0] TBL_ALIGN  = 64'h0000_0000_0000_03FF;
    // page-number bits used to index the table
    localparam logic [63:0] PAGE_SEL   = 64'h0000_0000_000F_E000;
    // byte offset inside a page
    localparam logic [63:0] PAGE_OFS   = 64'h0000_0000_0000_1FFF;
    // control register value after reset
    localparam logic [63:0] CTRL_RST   = 64'h0000_0021_0010_0000;

endpackage

// File: rtl/bwx_regs.sv
module bwx_regs
    import bwx_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int AW      = 64,
    parameter int WIN_W   = $clog2(NUM_WIN),
    parameter int SEL_W   = 2 + WIN_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [SEL_W-1:0]             cfg_sel,
    input  logic [AW-1:0]                cfg_wdata,
    output logic [AW-1:0]                cfg_rdata,
    output logic [NUM_WIN-1:0][AW-1:0]   win_base,
    output logic [NUM_WIN-1:0][AW-1:0]   win_mask,
    output logic [NUM_WIN-1:0][AW-1:0]   win_tbase
);

    typedef struct packed {
        logic [NUM_WIN-1:0][AW-1:0] base;
        logic [NUM_WIN-1:0][AW-1:0] mask;
        logic [NUM_WIN-1:0][AW-1:0] tbase;
        logic [AW-1:0]              ctrl;
    } regs_t;

    regs_t     regs_d, regs_q;
    reg_kind_e kind;
    logic [WIN_W-1:0] win;

    assign kind = reg_kind_e'(cfg_sel[SEL_W-1 -: 2]);
    assign win  = cfg_sel[WIN_W-1:0];

    always_comb begin
        regs_d = regs_q;
        if (cfg_we) begin
            case (kind)
                RK_BASE:  regs_d.base[win]  = cfg_wdata;
                RK_MASK:  regs_d.mask[win]  = cfg_wdata;
                RK_TBASE: regs_d.tbase[win] = cfg_wdata;
                default:  regs_d.ctrl       = cfg_wdata;
            endcase
        end
    end

    always_comb begin
        case (kind)
            RK_BASE:  cfg_rdata = regs_q.base[win];
            RK_MASK:  cfg_rdata = regs_q.mask[win];
            RK_TBASE: cfg_rdata = regs_q.tbase[win];
            default:  cfg_rdata = regs_q.ctrl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.ctrl <= AW'(CTRL_RST);
        end else begin
            regs_q      <= regs_d;
        end
    end

    assign win_base  = regs_q.base;
    assign win_mask  = regs_q.mask;
    assign win_tbase = regs_q.tbase;

endmodule

// File: rtl/bwx_match.sv
module bwx_match
    import bwx_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int AW      = 64
) (
    input  logic [AW-1:0]                bus_addr,
    input  logic [NUM_WIN-1:0][AW-1:0]   win_base,
    input  logic [NUM_WIN-1:0][AW-1:0]   win_mask,
    input  logic [NUM_WIN-1:0][AW-1:0]   win_tbase,
    output logic                         hit,
    output logic                         paged,
    output logic [AW-1:0]                lin_addr,
    output logic [AW-1:0]                tbl_addr
);

    localparam logic [AW-1:0] FIELD = AW'(WIN_FIELD);

    logic [NUM_WIN-1:0]          cand_hit;
    logic [NUM_WIN-1:0][AW-1:0]  cand_lin;
    logic [NUM_WIN-1:0][AW-1:0]  cand_tbl;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic [AW-1:0] span;
        logic [AW-1:0] cmp;
        logic [AW-1:0] keep;
        assign span        = win_mask[g] & FIELD;
        assign cmp         = ~win_mask[g] & FIELD;
        assign keep        = span | AW'(LIN_LOW);
        assign cand_hit[g] = win_base[g][0] &&
                             ((bus_addr & cmp) == (win_base[g] & cmp));
        assign cand_lin[g] = (win_tbase[g] & ~keep) | (bus_addr & keep);
        assign cand_tbl[g] = (win_tbase[g] & ~((span >> 10) | AW'(TBL_ALIGN)))
                           | ((bus_addr & (span | AW'(PAGE_SEL))) >> 10);
    end

    // lowest index wins: scan downwards so the last assignment is the lowest hit
    always_comb begin
        hit      = 1'b0;
        paged    = 1'b0;
        lin_addr = bus_addr;
        tbl_addr = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (cand_hit[i]) begin
                hit      = 1'b1;
                paged    = win_base[i][1];
                lin_addr = cand_lin[i];
                tbl_addr = cand_tbl[i];
            end
        end
    end

endmodule

// File: rtl/bwx_walk.sv
module bwx_walk
    import bwx_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          hit,
    input  logic          paged,
    input  logic [AW-1:0] lin_addr,
    input  logic [AW-1:0] tbl_addr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_data,
    output logic          resp_valid,
    output logic [AW-1:0] resp_addr
);

    typedef struct packed {
        xl_state_e     state;
        logic [AW-1:0] bus;
        logic [AW-1:0] ptr;
        logic [AW-1:0] result;
    } walk_t;

    walk_t walk_d, walk_q;

    always_comb begin
        walk_d = walk_q;
        case (walk_q.state)
            XS_IDLE: begin
                if (req_valid) begin
                    walk_d.bus = req_addr;
                    if (hit && paged) begin
                        walk_d.ptr   = tbl_addr;
                        walk_d.state = XS_WALK;
                    end else begin
                        walk_d.result = lin_addr;
                        walk_d.state  = XS_DONE;
                    end
                end
            end
            XS_WALK: begin
                if (mem_ack) begin
                    walk_d.result = ((mem_data & ~AW'(1)) << 12)
                                  | (walk_q.bus & AW'(PAGE_OFS));
                    walk_d.state  = XS_DONE;
                end
            end
            default: walk_d.state = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q       <= '0;
            walk_q.state <= XS_IDLE;
        end else begin
            walk_q       <= walk_d;
        end
    end

    assign req_ready  = (walk_q.state == XS_IDLE);
    assign mem_req    = (walk_q.state == XS_WALK);
    assign mem_addr   = walk_q.ptr;
    assign resp_valid = (walk_q.state == XS_DONE);
    assign resp_addr  = walk_q.result;

endmodule

// File: rtl/bus_window_xlate.sv
module bus_window_xlate
    import bwx_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int AW      = 64,
    localparam int WIN_W  = $clog2(NUM_WIN),
    localparam int SEL_W  = 2 + WIN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    output logic [AW-1:0]    cfg_rdata,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_addr,
    output logic             resp_valid,
    output logic [AW-1:0]    resp_addr,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_ack,
    input  logic [AW-1:0]    mem_data
);

    logic [NUM_WIN-1:0][AW-1:0] win_base, win_mask, win_tbase;
    logic                       hit, paged;
    logic [AW-1:0]              lin_addr, tbl_addr;

    bwx_regs #(.NUM_WIN(NUM_WIN), .AW(AW), .WIN_W(WIN_W), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .win_base  (win_base),
        .win_mask  (win_mask),
        .win_tbase (win_tbase)
    );

    bwx_match #(.NUM_WIN(NUM_WIN), .AW(AW)) u_match (
        .bus_addr  (req_addr),
        .win_base  (win_base),
        .win_mask  (win_mask),
        .win_tbase (win_tbase),
        .hit       (hit),
        .paged     (paged),
        .lin_addr  (lin_addr),
        .tbl_addr  (tbl_addr)
    );

    bwx_walk #(.AW(AW)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .hit        (hit),
        .paged      (paged),
        .lin_addr   (lin_addr),
        .tbl_addr   (tbl_addr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_data   (mem_data),
        .resp_valid (resp_valid),
        .resp_addr  (resp_addr)
    );

endmodule

// File: rtl/bwx_checker.sv
module bwx_checker #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          resp_valid,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr
);

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);                  // R9

    AST_RESP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> req_ready);                                 // R9

    AST_WALK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);                                   // R9

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);                               // R10

    AST_TBL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));  // R7

    AST_ACK_TO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> resp_valid);                      // R8

endmodule

bind bus_window_xlate bwx_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr)
);

// File: tb/bus_window_xlate_bench.sv
module bus_window_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic        resp_valid;
    logic [63:0] resp_addr;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_data = '0;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] m_base  [4];
    logic [63:0] m_mask  [4];
    logic [63:0] m_tbase [4];

    always #4 clk = ~clk;

    bus_window_xlate u_bus_window_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .resp_valid(resp_valid),
        .resp_addr(resp_addr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_data(mem_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] entry_of(input logic [63:0] a);
        return (a * 64'h0000_0001_0000_0003) ^ 64'h0000_0000_0ABC_D001;
    endfunction

    // bench model of the translation rules (R4, R5, R6, R7, R3)
    task automatic model(input logic [63:0] bus, output bit paged,
                         output logic [63:0] tbl, output logic [63:0] lin);
        bit found = 0;
        paged = 0; tbl = '0; lin = bus;
        for (int w = 0; w < 4; w++) begin
            logic [63:0] cmp, span, keep;
            cmp  = ~m_mask[w] & 64'hFFF0_0000;
            span = m_mask[w] & 64'hFFF0_0000;
            keep = span | 64'hF_FFFF;
            if (!found && m_base[w][0] && ((bus & cmp) == (m_base[w] & cmp))) begin
                found = 1;
                paged = m_base[w][1];
                lin   = (m_tbase[w] & ~keep) | (bus & keep);
                tbl   = (m_tbase[w] & ~((span >> 10) | 64'h3FF)) |
                        ((bus & (span | 64'hF_E000)) >> 10);
            end
        end
    endtask

    task automatic wr(input logic [1:0] kind, input int w, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = {kind, 2'(w)}; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (kind)
            2'd0: m_base[w]  = d;
            2'd1: m_mask[w]  = d;
            2'd2: m_tbase[w] = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [1:0] kind, input int w, input logic [63:0] exp, input string tag);
        @(negedge clk);
        cfg_sel = {kind, 2'(w)};
        #1;
        chk(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    task automatic xlate(input logic [63:0] bus, input string tag);
        bit paged, got, seen;
        logic [63:0] tbl, exp;
        int cyc, ack_cyc, delay;
        model(bus, paged, tbl, exp);
        got = 0; seen = 0; ack_cyc = -10; delay = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R9 ready before request"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_addr = bus;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!got && cyc < 40) begin
            if (resp_valid) begin
                got = 1;
                if (paged) begin
                    chk(cyc == ack_cyc + 1, {tag, " R8 timing"}, 64'(cyc), 64'(ack_cyc + 1));
                    chk(resp_addr == exp, {tag, " R8 result"}, resp_addr, exp);
                end else begin
                    chk(cyc == 1, {tag, " R3/R6 timing"}, 64'(cyc), 64'd1);
                    chk(resp_addr == exp, {tag, " R6 result"}, resp_addr, exp);
                    chk(!seen, {tag, " R3 no memory read"}, 64'(seen), 64'd0);
                end
                chk(req_ready == 1'b0, {tag, " R9 busy at result"}, 64'(req_ready), 64'd0);
            end else begin
                chk(req_ready == 1'b0, {tag, " R9 busy"}, 64'(req_ready), 64'd0);
                if (mem_req) begin
                    if (!seen) begin
                        seen = 1;
                        chk(paged, {tag, " R7 unexpected table read"}, 64'(paged), 64'd1);
                        chk(mem_addr == tbl, {tag, " R7 table address"}, mem_addr, tbl);
                        delay = int'($urandom % 3);
                    end
                    if (delay == 0) begin
                        mem_ack  = 1'b1;
                        mem_data = entry_of(mem_addr);
                        exp = ((mem_data & ~64'd1) << 12) | (bus & 64'h1FFF);
                        ack_cyc = cyc;
                    end else begin
                        delay--;
                    end
                end
            end
            @(negedge clk);
            mem_ack = 1'b0;
            cyc++;
        end
        chk(got, {tag, " R10 result seen"}, 64'(got), 64'd1);
        chk(resp_valid == 1'b0, {tag, " R10 single pulse"}, 64'(resp_valid), 64'd0);
        chk(req_ready == 1'b1, {tag, " R9 ready after result"}, 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int w = 0; w < 4; w++) begin
            m_base[w] = '0; m_mask[w] = '0; m_tbase[w] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
        chk(resp_valid == 1'b0, "R1 resp_valid", 64'(resp_valid), 64'd0);
        chk(mem_req == 1'b0, "R1 mem_req", 64'(mem_req), 64'd0);
        rd(2'd3, 0, 64'h0000_0021_0010_0000, "R1 control reset");
        for (int w = 0; w < 4; w++) begin
            rd(2'd0, w, 64'd0, "R1 base reset");
            rd(2'd1, w, 64'd0, "R1 mask reset");
            rd(2'd2, w, 64'd0, "R1 target reset");
        end

        // R3 all windows disabled
        xlate(64'h1234_5678_9ABC_DEF0, "R3 pass-through");

        // R2 register access
        wr(2'd3, 2, 64'hDEAD_BEEF_0123_4567);
        rd(2'd3, 1, 64'hDEAD_BEEF_0123_4567, "R2 control readback");
        for (int w = 0; w < 4; w++) begin
            logic [63:0] v = {$urandom, $urandom};
            wr(2'd2, w, v);
            rd(2'd2, w, v, "R2 target readback");
        end

        // R4: window 0 matches but is disabled, window 1 enabled linear
        wr(2'd0, 0, 64'h4000_0000);
        wr(2'd1, 0, 64'h0);
        wr(2'd2, 0, 64'hFFFF_0000_0000_0000);
        wr(2'd0, 1, 64'h4000_0001);
        wr(2'd1, 1, 64'h00F0_0000);
        wr(2'd2, 1, 64'h1_2300_0000);
        wr(2'd0, 2, 64'h0);
        wr(2'd0, 3, 64'h0);
        xlate(64'h4012_3456, "R4 disabled window skipped");
        chk(resp_addr == 64'h1_2312_3456, "R6 linear directed", resp_addr, 64'h1_2312_3456);

        // R5: enable window 0 too, lower index wins
        wr(2'd0, 0, 64'h4000_0001);
        wr(2'd1, 0, 64'h00F0_0000);
        xlate(64'h4012_3456, "R5 priority");
        chk(resp_addr[63:48] == 16'hFFFF, "R5 window 0 chosen", resp_addr, 64'hFFFF_0000_0012_3456);

        // R4: address outside the compare field passes through
        xlate(64'h5012_3456, "R4 miss");
        chk(resp_addr == 64'h5012_3456, "R3 miss returns input", resp_addr, 64'h5012_3456);

        // R7/R8 page-table directed
        wr(2'd0, 2, 64'h8000_0003);
        wr(2'd1, 2, 64'h0);
        wr(2'd2, 2, 64'h10_0000);
        xlate(64'h8000_4ABC, "R7 paged directed");

        // random windows and addresses
        for (int it = 0; it < 80; it++) begin
            int w;
            logic [63:0] bus;
            if (it % 10 == 0) begin
                for (int k = 0; k < 4; k++) begin
                    wr(2'd0, k, {32'($urandom), $urandom & 32'hFFF0_0000} | 64'($urandom % 4));
                    wr(2'd1, k, 64'($urandom & 32'h0FF0_0000));
                    wr(2'd2, k, {$urandom, $urandom});
                end
            end
            w = int'($urandom % 4);
            bus = {$urandom, $urandom};
            if ($urandom % 4 != 0)
                bus = {bus[63:32], m_base[w][31:20] ^ (bus[31:20] & m_mask[w][31:20]), bus[19:0]};
            xlate(bus, "R6/R8 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule